// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor run management transactions on an Ethernet PHY over the two-wire MDC/MDIO bus. The host reaches it through a small register-bus slave port with five 32-bit registers. A single format bit selects the frame type: either the short-address frame (Clause 22) or the extended indirect-address frame (Clause 45). The command register starts one frame at a time. A busy flag tells the host when the next frame may be issued.

The block produces every frame itself. It sends a preamble of 32 ones and then the start, opcode, port, register/device and turnaround fields, followed by 16 data bits, all MSB first. The master moves MDIO only while MDC is low. During a read it releases the line for the turnaround and the data bits, and it samples the PHY on each MDC rising edge. An extended access takes two commands: an address frame whose payload comes from the write-data register, then a write frame or a read frame. The host loads the write-data register again between the two. MDC comes from the system clock through a divider fixed at elaboration. The default gives 2.5 MHz from a 200 MHz clock, and MDC stays low between frames.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: Register map, offsets in bytes. The format bit is bit 8 at 0x40 (0 = Clause 22, 1 = Clause 45). The address register is at 0x44, with the port address in bits 12:8 and the register or device number in bits 4:0. The write-data register is at 0x48, bits 15:0. Each of these reads back what was written in those bits and 0 elsewhere.
- R3: Every frame is 64 bit times: 32 ones, then ST(2) OP(2) PORT(5) REG/DEV(5) TA(2) DATA(16), MSB first. The master changes `mdio_o` only while MDC is low. In write and address frames the master drives TA as 1 then 0.
- R4: With format bit 0, code 0 in command bits 1:0 sends a read frame with ST=01 and OP=10. The master releases MDIO for bit times 46 to 63 and samples `mdio_i` on each MDC rising edge in bit times 48 to 63. When the frame ends, the 16 sampled bits appear in bits 15:0 at 0x4C.
- R5: With format bit 0, code 1 sends a write frame with ST=01, OP=01 and DATA taken from the write-data register.
- R6: With format bit 1, code 0 sends an address frame with ST=00 and OP=00. Bits 4:0 of the address register give the device field, and the write-data register gives the payload.
- R7: With format bit 1, code 1 sends a write frame (ST=00, OP=01, DATA from write-data). Code 2 sends a read frame (ST=00, OP=11), whose data is released, sampled and stored as in R4.
- R8: Each MDC high phase and each MDC low phase lasts MDC_HALF system clocks. A frame has exactly 64 MDC rising edges, and MDC stays low while idle.
- R9: A write to the command register at 0x50 with bit 8 clear starts nothing.
- R10: Bit 16 at 0x50 reads 1 from the cycle after a command is accepted until the frame ends, and reads 0 otherwise.
- R11: A command written while bit 16 is 1 is ignored and produces no extra frame.
- R12: An unsupported code starts nothing: code 2 or 3 with format bit 0, and code 3 with format bit 1.
- R13: The value at 0x4C changes only when a read frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte address |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line value as seen by the master |

## Verification
A wrong bit counter or shift position shows up on the line within one frame. A field lands in the wrong bit time, or a frame does not have exactly 64 MDC rising edges, and the scoreboard compares each whole 64-bit frame at its last rising edge. A wrong release window for reads shows at the first rising edge where the master still drives, or in the captured value at 0x4C once busy clears. A wrong divider count shows in the first MDC phase after a command. A stuck or early busy flag shows on the next poll of 0x50, or as a frame that arrives without a matching expected item.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_HALF = 40,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);

  localparam int DW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [AW-1:0] A_MODE = AW'('h40);
  localparam logic [AW-1:0] A_ADDR = AW'('h44);
  localparam logic [AW-1:0] A_WVAL = AW'('h48);
  localparam logic [AW-1:0] A_RVAL = AW'('h4C);
  localparam logic [AW-1:0] A_CMD  = AW'('h50);

  logic          c45;
  logic [4:0]    port_r, reg_r;
  logic [15:0]   wval, rval, cap;
  logic          busy, rd_op;
  logic [63:0]   sh;
  logic [5:0]    bitn;
  logic [DW-1:0] div;
  logic [1:0]    st, op;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[15:13], bus_wdata[7:5]};

  wire [1:0] code    = bus_wdata[1:0];
  wire       code_ok = c45 ? (code != 2'd3) : (code[1] == 1'b0);
  wire       go      = bus_wen && (bus_addr == A_CMD) && bus_wdata[8] && !busy && code_ok;
  wire       new_rd  = c45 ? (code == 2'd2) : (code == 2'd0);
  wire       tick    = (div == DW'(MDC_HALF - 1));

  always_comb begin
    if (c45) begin
      st = 2'b00;
      op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    end else begin
      st = 2'b01;
      op = (code == 2'd0) ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c45    <= 1'b0;
      port_r <= '0;
      reg_r  <= '0;
      wval   <= '0;
    end else if (bus_wen) begin
      if (bus_addr == A_MODE) c45 <= bus_wdata[8];
      if (bus_addr == A_ADDR) begin
        port_r <= bus_wdata[12:8];
        reg_r  <= bus_wdata[4:0];
      end
      if (bus_addr == A_WVAL) wval <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_op   <= 1'b0;
      sh      <= '0;
      bitn    <= '0;
      div     <= '0;
      mdc     <= 1'b0;
      mdio_oe <= 1'b0;
      cap     <= '0;
      rval    <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      rd_op   <= new_rd;
      sh      <= {32'hFFFF_FFFF, st, op, port_r, reg_r, 2'b10, wval};
      bitn    <= '0;
      div     <= '0;
      mdc     <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_op && bitn >= 6'd48) cap <= {cap[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bitn == 6'd63) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            if (rd_op) rval <= cap;
          end else begin
            bitn    <= bitn + 1'b1;
            sh      <= {sh[62:0], 1'b1};
            mdio_oe <= !(rd_op && bitn >= 6'd45);
          end
        end
      end
    end
  end

  assign mdio_o = sh[63];

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {23'd0, c45, 8'd0};
      A_ADDR:  bus_rdata = {19'd0, port_r, 3'd0, reg_r};
      A_WVAL:  bus_rdata = {16'd0, wval};
      A_RVAL:  bus_rdata = {16'd0, rval};
      A_CMD:   bus_rdata = {15'd0, busy, 16'd0};
      default: bus_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          bus_wen,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata
);

  wire cmd_wr = bus_wen && (bus_addr == AW'('h50));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  mdc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |=> $stable(mdc));

  // R4
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(busy));

  // R3
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[8] && bus_wdata[1:0] == 2'd1 && !busy) |=> busy);

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !bus_wdata[8] && !busy) |=> !busy);

endmodule

bind mdio_master mdio_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int HALF = 40;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wen = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;
  logic [15:0] phy_resp = 16'h0;

  int checks = 0, errors = 0, frames_seen = 0;
  bit done = 0;
  logic [64:0] exp_q[$];

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_master #(.MDC_HALF(HALF), .AW(8)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do bus_read(8'h50, v); while (v[16]);
  endtask

  function automatic logic [63:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, p, r, 2'b10, d};
  endfunction

  // driver: push expected frame, then issue command
  task automatic issue(input logic [31:0] cmd, input logic [63:0] frame, input bit rd);
    exp_q.push_back({rd, frame});
    bus_write(8'h50, cmd);
  endtask

  // monitor: capture 64 rising edges per frame, act as PHY during reads
  initial begin
    forever begin
      logic [64:0] e;
      logic [63:0] got;
      e = '0;
      got = '0;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        if (k == 0) begin
          if (exp_q.size() == 0) check(0, "R11 unexpected frame", 64'd1, 64'd0);
          else e = exp_q[0];
        end
        got[63-k] = mdio_i;
        if (e[64] && k >= 46 && mdio_oe) check(0, "R4 master drives in read window", 64'(k), 64'd0);
        if (k < 63) begin
          @(negedge mdc);
          if (e[64] && k + 1 == 47) phy_drv = 1'b0;
          else if (e[64] && k + 1 >= 48) phy_drv = phy_resp[62-k];
          else phy_drv = 1'b1;
        end
      end
      phy_drv = 1'b1;
      frames_seen++;
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        check(got == e[63:0], "R3 frame content", got, e[63:0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi, lo, n0;
    repeat (4) @(negedge clk);
    #1;
    check(mdc == 0 && mdio_oe == 0, "R1 pins", {mdc, mdio_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    foreach (v[i]) begin end
    for (int a = 'h40; a <= 'h50; a += 4) begin
      bus_read(8'(a), v);
      check(v == 0, "R1 reg reset", v, 0);
    end

    bus_write(8'h44, 32'hFFFF_1A33);
    bus_read(8'h44, v); check(v == 32'h0000_1A13, "R2 address reg", v, 32'h1A13);
    bus_write(8'h48, 32'h1234_BEEF);
    bus_read(8'h48, v); check(v == 32'h0000_BEEF, "R2 wdata reg", v, 32'hBEEF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h40, v); check(v == 32'h100, "R2 mode reg", v, 32'h100);
    bus_write(8'h40, 32'h0);

    // R9 start bit clear
    bus_write(8'h50, 32'h1);
    bus_read(8'h50, v); check(v[16] == 0, "R9 no start", v, 0);
    // R12 unsupported codes
    bus_write(8'h50, 32'h102);
    bus_read(8'h50, v); check(v[16] == 0, "R12 c22 code2", v, 0);
    bus_write(8'h40, 32'h100);
    bus_write(8'h50, 32'h103);
    bus_read(8'h50, v); check(v[16] == 0, "R12 c45 code3", v, 0);
    bus_write(8'h40, 32'h0);

    // R5 clause 22 write, R10 busy, R8 timing, R11 ignored command
    bus_write(8'h44, 32'h0000_0511);
    bus_write(8'h48, 32'h0000_A5C3);
    issue(32'h101, mk(2'b01, 2'b01, 5'h05, 5'h11, 16'hA5C3), 0);
    bus_read(8'h50, v); check(v[16] == 1, "R10 busy after start", v, 32'h10000);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    check(hi == HALF, "R8 high phase", 64'(hi), 64'(HALF));
    check(lo == HALF, "R8 low phase", 64'(lo), 64'(HALF));
    bus_write(8'h50, 32'h100);
    wait_idle();
    repeat (4 * HALF) @(negedge clk);
    check(frames_seen == 1, "R11 single frame", 64'(frames_seen), 1);
    check(mdc == 0, "R8 idle low", mdc, 0);

    // R4 clause 22 read
    phy_resp = 16'h3C96;
    issue(32'h100, mk(2'b01, 2'b10, 5'h05, 5'h11, 16'h3C96), 1);
    wait_idle();
    bus_read(8'h4C, v); check(v == 32'h3C96, "R4 read data", v, 32'h3C96);

    // R6 clause 45 address then R7 write
    bus_write(8'h40, 32'h100);
    bus_write(8'h44, 32'h0000_1E07);
    bus_write(8'h48, 32'h0000_8001);
    issue(32'h100, mk(2'b00, 2'b00, 5'h1E, 5'h07, 16'h8001), 0);
    wait_idle();
    bus_write(8'h48, 32'h0000_0F0F);
    issue(32'h101, mk(2'b00, 2'b01, 5'h1E, 5'h07, 16'h0F0F), 0);
    wait_idle();
    bus_read(8'h4C, v); check(v == 32'h3C96, "R13 read data kept", v, 32'h3C96);

    // R7 clause 45 read
    bus_write(8'h48, 32'h0000_0002);
    issue(32'h100, mk(2'b00, 2'b00, 5'h1E, 5'h07, 16'h0002), 0);
    wait_idle();
    phy_resp = 16'hE41B;
    issue(32'h102, mk(2'b00, 2'b11, 5'h1E, 5'h07, 16'hE41B), 1);
    wait_idle();
    bus_read(8'h4C, v); check(v == 32'hE41B, "R7 c45 read data", v, 32'hE41B);

    repeat (4 * HALF) @(negedge clk);
    n0 = exp_q.size();
    check(n0 == 0, "R11 queue drained", 64'(n0), 0);
    check(frames_seen == 6, "R3 frame count", 64'(frames_seen), 6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule